// File: doc/BRIEF.md
# Traffic Intersection Sequencing Controller

This block is the state machine that drives the lamps of a crossing between a busy main street and a quieter side street. In run mode it steps through main green, main yellow, an optional pedestrian phase, side green (stretched once if cars are still waiting) and side yellow, then starts over. Each timed phase asks an external interval timer to begin counting. It names the interval it needs by a two-bit parameter address and waits for the timer's expired flag.

The same machine serves a blink mode, used at night or on a fault, and two maintenance commands: examine and store. These commands put a chosen location on the parameter address, with or without a write strobe, so that an operator can read or load the four interval values. Interval counting, parameter storage, input synchronizers and the walk-request latch all lie outside the block. The block clears that latch with a one-clock pulse.

Top module: `traffic_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, all six lamps are off, the write strobe and timer start are low, and the walk-clear output is high.
- R2: Mode select is 00 examine, 01 store, 10 run, 11 blink. From idle, a GO pulse with examine drives the location input onto the parameter address for one cycle with no write. A GO pulse with store does the same with exactly one write clock. Without GO, nothing is written.
- R3: Each timed phase raises timer start for one clock on entry, with its parameter address: 00 yellow, 01 base, 10 extended, 11 blink.
- R4: A timed phase ends only on an expired flag seen after its entry cycle. With a timer that expires T cycles after loading, a phase lasts T+1 cycles.
- R5: Lamp buses are {red, yellow, green} in bits 2..0. Main green with side red lasts a base period followed by an extended period.
- R6: Next, main yellow with side red lasts one yellow period.
- R7: If a walk request is pending at the end of main yellow, both streets show red+yellow (110) for one extended period. Walk-clear pulses for one clock at the start of this phase. A request raised during the phase does not lengthen it.
- R8: Side green with main red lasts one base period. If the sensor is high at its end, the phase runs one more base period, and no more than one.
- R9: After side green, side yellow with main red lasts one yellow period, and main green follows.
- R10: Blink mode alternates main yellow with side red (on) and all lamps off, each half one blink period.
- R11: Changing the mode select away from run or blink returns the block to idle with all lamps off on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sensor_i | input | 1 | Side-street vehicle present (synchronized) |
| walk_req_i | input | 1 | Latched walk request |
| expired_i | input | 1 | Interval timer finished |
| go_i | input | 1 | One-cycle command pulse |
| func_i | input | 2 | Mode select |
| loc_i | input | 2 | Parameter location for examine/store |
| timer_start_o | output | 1 | Start interval timer |
| param_addr_o | output | 2 | Parameter address |
| param_we_o | output | 1 | Parameter write strobe |
| walk_clr_o | output | 1 | Clear the walk latch |
| main_lamp_o | output | 3 | Main street {red, yellow, green} |
| side_lamp_o | output | 3 | Side street {red, yellow, green} |

## Verification
The bench models the parameter memory and the interval timer. It loads the intervals through store commands and reads them back through examine, so durations follow from values the bench wrote itself. Run mode is tried with sensor and walk both low, which gives the plain four-phase cycle. It is also tried with both high: this separates the inserted walk phase and the single side-green extension from the plain cycle, and shows that a held sensor does not extend the side green twice. Blink alternation is checked, as are exits from run and blink mode and a store select held without GO.

// File: rtl/tl_pkg.sv
package tl_pkg;
  localparam int LAMP_W  = 3;
  localparam int PADDR_W = 2;
  localparam int FUNC_W  = 2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_EXAM, ST_STORE,
    ST_MG_BASE, ST_MG_EXT, ST_MY, ST_WALK,
    ST_SG, ST_SG_EXTRA, ST_SY,
    ST_BLK_ON, ST_BLK_OFF
  } tl_state_e;

  localparam logic [FUNC_W-1:0] FN_EXAMINE = 2'b00;
  localparam logic [FUNC_W-1:0] FN_STORE   = 2'b01;
  localparam logic [FUNC_W-1:0] FN_RUN     = 2'b10;
  localparam logic [FUNC_W-1:0] FN_BLINK   = 2'b11;

  localparam logic [PADDR_W-1:0] P_YEL   = 2'b00;
  localparam logic [PADDR_W-1:0] P_BASE  = 2'b01;
  localparam logic [PADDR_W-1:0] P_EXT   = 2'b10;
  localparam logic [PADDR_W-1:0] P_BLINK = 2'b11;

  localparam logic [LAMP_W-1:0] L_OFF = 3'b000;
  localparam logic [LAMP_W-1:0] L_RED = 3'b100;
  localparam logic [LAMP_W-1:0] L_YEL = 3'b010;
  localparam logic [LAMP_W-1:0] L_GRN = 3'b001;
  localparam logic [LAMP_W-1:0] L_RY  = 3'b110;
endpackage

// File: rtl/tl_lamp_decode.sv
module tl_lamp_decode
  import tl_pkg::*;
(
  input  tl_state_e          st,
  output logic [LAMP_W-1:0]  main_l,
  output logic [LAMP_W-1:0]  side_l
);
  always_comb begin
    main_l = L_OFF;
    side_l = L_OFF;
    case (st)
      ST_MG_BASE, ST_MG_EXT: begin main_l = L_GRN; side_l = L_RED; end
      ST_MY:                 begin main_l = L_YEL; side_l = L_RED; end
      ST_WALK:               begin main_l = L_RY;  side_l = L_RY;  end
      ST_SG, ST_SG_EXTRA:    begin main_l = L_RED; side_l = L_GRN; end
      ST_SY:                 begin main_l = L_RED; side_l = L_YEL; end
      ST_BLK_ON:             begin main_l = L_YEL; side_l = L_RED; end
      default:               begin main_l = L_OFF; side_l = L_OFF; end
    endcase
  end
endmodule

// File: rtl/tl_param_map.sv
module tl_param_map
  import tl_pkg::*;
(
  input  tl_state_e           st,
  input  logic [PADDR_W-1:0]  loc,
  output logic [PADDR_W-1:0]  addr,
  output logic                timed
);
  always_comb begin
    timed = 1'b1;
    addr  = P_YEL;
    case (st)
      ST_MG_BASE, ST_SG, ST_SG_EXTRA: addr = P_BASE;
      ST_MG_EXT, ST_WALK:             addr = P_EXT;
      ST_MY, ST_SY:                   addr = P_YEL;
      ST_BLK_ON, ST_BLK_OFF:          addr = P_BLINK;
      ST_EXAM, ST_STORE:     begin addr = loc; timed = 1'b0; end
      default:               begin addr = P_YEL; timed = 1'b0; end
    endcase
  end
endmodule

// File: rtl/traffic_seq.sv
module traffic_seq
  import tl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sensor_i,
  input  logic               walk_req_i,
  input  logic               expired_i,
  input  logic               go_i,
  input  logic [1:0]         func_i,
  input  logic [1:0]         loc_i,
  output logic               timer_start_o,
  output logic [1:0]         param_addr_o,
  output logic               param_we_o,
  output logic               walk_clr_o,
  output logic [2:0]         main_lamp_o,
  output logic [2:0]         side_lamp_o
);
  tl_state_e state, state_n;
  logic [LAMP_W-1:0]  main_n, side_n;
  logic [PADDR_W-1:0] addr_n;
  logic               timed_n;
  logic               done;

  // The timer may still show a stale flag in the entry cycle.
  assign done = expired_i && !timer_start_o;

  always_comb begin
    state_n = state;
    case (state)
      ST_IDLE:
        if (go_i) begin
          case (func_i)
            FN_EXAMINE: state_n = ST_EXAM;
            FN_STORE:   state_n = ST_STORE;
            FN_RUN:     state_n = ST_MG_BASE;
            default:    state_n = ST_BLK_ON;
          endcase
        end
      ST_EXAM, ST_STORE: state_n = ST_IDLE;
      ST_BLK_ON, ST_BLK_OFF:
        if (func_i != FN_BLINK)   state_n = ST_IDLE;
        else if (done)            state_n = (state == ST_BLK_ON) ? ST_BLK_OFF : ST_BLK_ON;
      default:
        if (func_i != FN_RUN) state_n = ST_IDLE;
        else if (done) begin
          case (state)
            ST_MG_BASE:  state_n = ST_MG_EXT;
            ST_MG_EXT:   state_n = ST_MY;
            ST_MY:       state_n = walk_req_i ? ST_WALK : ST_SG;
            ST_WALK:     state_n = ST_SG;
            ST_SG:       state_n = sensor_i ? ST_SG_EXTRA : ST_SY;
            ST_SG_EXTRA: state_n = ST_SY;
            ST_SY:       state_n = ST_MG_BASE;
            default:     state_n = ST_IDLE;
          endcase
        end
    endcase
  end

  tl_lamp_decode u_lamps (.st(state_n), .main_l(main_n), .side_l(side_n));
  tl_param_map   u_pmap  (.st(state_n), .loc(loc_i), .addr(addr_n), .timed(timed_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      main_lamp_o   <= L_OFF;
      side_lamp_o   <= L_OFF;
      timer_start_o <= 1'b0;
      param_addr_o  <= P_YEL;
      param_we_o    <= 1'b0;
      walk_clr_o    <= 1'b1;
    end else begin
      state         <= state_n;
      main_lamp_o   <= main_n;
      side_lamp_o   <= side_n;
      timer_start_o <= timed_n && (state_n != state);
      param_addr_o  <= addr_n;
      param_we_o    <= (state_n == ST_STORE);
      walk_clr_o    <= (state_n == ST_WALK) && (state != ST_WALK);
    end
  end
endmodule

// File: rtl/traffic_seq_checker.sv
module traffic_seq_checker (
  input logic       clk,
  input logic       rst,
  input logic       timer_start_o,
  input logic       param_we_o,
  input logic       walk_clr_o,
  input logic [2:0] main_lamp_o,
  input logic [2:0] side_lamp_o
);
  // R2: a store never overlaps a lit phase and lasts one clock
  assert_we_lamps_dark_R2: assert property (@(posedge clk) disable iff (rst)
    param_we_o |-> (main_lamp_o == 3'b000 && side_lamp_o == 3'b000));
  assert_we_single_R2: assert property (@(posedge clk) disable iff (rst)
    param_we_o |=> !param_we_o);
  // R3: start strobe is one clock wide
  assert_start_single_R3: assert property (@(posedge clk) disable iff (rst)
    timer_start_o |=> !timer_start_o);
  // R7: walk clear outside reset only with walk lamps
  assert_clr_in_walk_R7: assert property (@(posedge clk) disable iff (rst)
    (walk_clr_o && !$past(rst)) |-> (main_lamp_o == 3'b110 && side_lamp_o == 3'b110));
  // R5: never both greens
  assert_no_dual_green_R5: assert property (@(posedge clk) disable iff (rst)
    !(main_lamp_o[0] && side_lamp_o[0]));
  // R8: side green implies main red only
  assert_side_green_main_red_R8: assert property (@(posedge clk) disable iff (rst)
    side_lamp_o[0] |-> (main_lamp_o == 3'b100));
endmodule

bind traffic_seq traffic_seq_checker u_chk (
  .clk(clk), .rst(rst), .timer_start_o(timer_start_o), .param_we_o(param_we_o),
  .walk_clr_o(walk_clr_o), .main_lamp_o(main_lamp_o), .side_lamp_o(side_lamp_o));

// File: tb/traffic_seq_test.sv
module traffic_seq_test;
  logic clk = 0, rst = 1;
  logic sensor = 0, walk_req = 0, go = 0;
  logic [1:0] func = 2'b00, loc = 2'b00;
  logic start, we, wclr, expired;
  logic [1:0] paddr;
  logic [2:0] mlamp, slamp;
  logic [7:0] mem [4];
  logic [7:0] cnt;
  int nchk = 0, nfail = 0;
  int vals [4] = '{2, 3, 4, 2}; // yellow, base, extended, blink

  always #5 clk = ~clk;

  traffic_seq uut (.clk(clk), .rst(rst), .sensor_i(sensor), .walk_req_i(walk_req),
    .expired_i(expired), .go_i(go), .func_i(func), .loc_i(loc),
    .timer_start_o(start), .param_addr_o(paddr), .param_we_o(we),
    .walk_clr_o(wclr), .main_lamp_o(mlamp), .side_lamp_o(slamp));

  // parameter memory and interval timer models
  always_ff @(posedge clk) begin
    if (we) mem[paddr] <= 8'(vals[paddr]);
    if (rst) cnt <= 0;
    else if (start) cnt <= mem[paddr];
    else if (cnt != 0) cnt <= cnt - 1;
  end
  assign expired = (cnt == 8'd1);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  task automatic command(input logic [1:0] f, input logic [1:0] l);
    func = f; loc = l; go = 1;
    @(negedge clk); go = 0;
  endtask

  // At the first sample of a phase: check strobe, address, lamps, then count cycles.
  task automatic phase(input logic [2:0] em, input logic [2:0] es, input logic [1:0] ea,
                       input int len, input string tag);
    int n = 0;
    check(start == 1'b1, {tag, " start"}, int'(start), 1);
    check(paddr == ea, {tag, " addr"}, int'(paddr), int'(ea));
    check(mlamp == em && slamp == es, {tag, " lamps"}, int'({mlamp, slamp}), int'({em, es}));
    while (mlamp == em && slamp == es && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(n == len, {tag, " length"}, n, len);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=0 expected=1");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(mlamp == 0 && slamp == 0, "R1 lamps", int'({mlamp, slamp}), 0);
    check(wclr && !we && !start, "R1 strobes", int'({wclr, we, start}), 4);
    rst = 0;
    @(negedge clk);
    check(wclr == 1'b0, "R1 clear drops", int'(wclr), 0);

    // R2: store selected without GO writes nothing
    func = 2'b01; loc = 2'b10;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(we == 1'b0, "R2 no GO", int'(we), 0);
    end
    // R2: one write clock per GO
    for (int k = 0; k < 4; k++) begin
      command(2'b01, 2'(k));
      check(we == 1'b1 && paddr == 2'(k), "R2 store", int'({we, paddr}), 4 + k);
      @(negedge clk);
      check(we == 1'b0, "R2 store single", int'(we), 0);
    end
    // R2: examine puts the location on the address, no write
    for (int k = 3; k >= 0; k--) begin
      command(2'b00, 2'(k));
      check(we == 1'b0 && paddr == 2'(k), "R2 examine", int'({we, paddr}), k);
      check(int'(mem[paddr]) == vals[k], "R2 readback", int'(mem[paddr]), vals[k]);
      @(negedge clk);
    end

    // Plain run cycle: no walk, no traffic
    command(2'b10, 2'b00);
    phase(3'b001, 3'b100, 2'b01, vals[1] + vals[2] + 2, "R5 R4 main green");
    phase(3'b010, 3'b100, 2'b00, vals[0] + 1, "R6 main yellow");
    phase(3'b100, 3'b001, 2'b01, vals[1] + 1, "R8 side green");
    phase(3'b100, 3'b010, 2'b00, vals[0] + 1, "R9 side yellow");
    // Walk pending and sensor held high
    walk_req = 1; sensor = 1;
    phase(3'b001, 3'b100, 2'b01, vals[1] + vals[2] + 2, "R9 R5 main green again");
    phase(3'b010, 3'b100, 2'b00, vals[0] + 1, "R6 yellow before walk");
    check(wclr == 1'b1, "R7 clear pulse", int'(wclr), 1);
    walk_req = 1; // re-pressed during the walk phase
    phase(3'b110, 3'b110, 2'b10, vals[2] + 1, "R7 walk");
    walk_req = 0;
    phase(3'b100, 3'b001, 2'b01, 2 * (vals[1] + 1), "R8 extended once");
    sensor = 0;
    phase(3'b100, 3'b010, 2'b00, vals[0] + 1, "R9 side yellow after ext");
    // R11: leave run mode
    func = 2'b00;
    @(negedge clk);
    check(mlamp == 0 && slamp == 0, "R11 run exit", int'({mlamp, slamp}), 0);
    @(negedge clk);

    // Blink mode
    command(2'b11, 2'b00);
    phase(3'b010, 3'b100, 2'b11, vals[3] + 1, "R10 blink on");
    phase(3'b000, 3'b000, 2'b11, vals[3] + 1, "R10 blink off");
    phase(3'b010, 3'b100, 2'b11, vals[3] + 1, "R10 blink on again");
    func = 2'b10;
    @(negedge clk);
    check(mlamp == 0 && slamp == 0, "R11 blink exit", int'({mlamp, slamp}), 0);
    report();
  end
endmodule